// File: doc/BRIEF.md
# I2C Master SCL Phase Timer

This block sets the clock timing for an I2C master. A 32-bit divider word holds two 16-bit counts. The lower half, L, sets the length of the SCL-low phase. The upper half, H, sets the length of the SCL-high phase. Each count is scaled by a fixed factor of eight, so the low phase lasts 8*(L+1) source clocks and the high phase lasts 8*(H+1). A full SCL period is therefore 8*((L+1)+(H+1)) source clocks. Every period begins with its low phase.

The block drives four kinds of output:
- An open-drain style SCL drive level.
- Two phase indications, one for low and one for high.
- Single-cycle strobes at the falling edge and the rising edge of SCL.
- A data-change strobe at the middle of the low phase and a sample strobe at the middle of the high phase.

The byte-level engine outside this block uses these strobes to shift SDA. While the high phase runs, the block watches the SCL line. If a slave still holds SCL low, the high-phase count stops until the line reads high, so a slave can stretch the clock.

Software is expected to split a total divisor D by putting ceil(D/2) into H and D-ceil(D/2) into L. The divider word is captured only when a period starts. The run enable parks SCL released high and clears all timing state. The SCL input is taken to be already synchronous to the source clock.

Top module: `scl_split_divider`

## Requirements
- R1: The divider word holds L in bits 15:0 and H in bits 31:16. With no stretching, consecutive falling-edge strobes are 8*((L+1)+(H+1)) source clocks apart.
- R2: Each period begins with the low phase, lasting 8*(L+1) cycles, then the high phase, lasting 8*(H+1) cycles. During the low phase, phase_low is 1 and scl_o is 0. During the high phase, phase_high is 1 and scl_o is 1. The two phase indications are never both 1.
- R3: L=0 and H=0 is a legal setting and gives the shortest period, 16 source clocks.
- R4: When a total divisor D is split as H=ceil(D/2) and L=D-H, the period is 8*(D+2) source clocks. For example, D=5 gives 56.
- R5: A divider word changed during a period has no effect until the next period begins. The new value takes effect from that period's low phase.
- R6: While phase_high is 1 and scl_in reads 0, the high-phase count does not advance. Every cycle held this way lengthens the high phase by one cycle.
- R7: chg_stb is 1 for exactly one cycle per period. That cycle is the one 4*(L+1) cycles after the falling-edge strobe.
- R8: smp_stb is 1 for exactly one cycle per period. That cycle is the one in which the high-phase count reaches 4*(H+1) while scl_in is 1. With no stretching, this is 8*(L+1)+4*(H+1) cycles after the falling-edge strobe.
- R9: fall_stb is 1 only in the first cycle of a low phase, and rise_stb only in the first cycle of a high phase. Each phase gives one strobe, even when the high phase is stretched.
- R10: During reset, or one cycle after run_en is 0:
  - scl_o is 1.
  - Both phase indications are 0.
  - No strobe fires.

  When run_en returns to 1, the next cycle starts a full-length low phase using the current divider word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Enables SCL generation; 0 parks SCL high and clears the counters |
| div_cfg | input | 32 | Divider word: bits 15:0 low count L, bits 31:16 high count H |
| scl_in | input | 1 | Sampled SCL line level, used to detect stretching |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| phase_low | output | 1 | SCL low phase in progress |
| phase_high | output | 1 | SCL high phase in progress |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle of a high phase |
| chg_stb | output | 1 | Midpoint of the low phase (SDA may change) |
| smp_stb | output | 1 | Midpoint of the high phase (SDA sample point) |

## Verification
The timing is tried with several divider words:
- Symmetric pairs, which cannot distinguish swapped fields.
- Pairs where only one field is nonzero, which expose swapped halves or a shared count.
- Unequal large pairs, which check that the midpoint strobes scale per field.
- The all-zero word, which checks the minimum period.

A word changed in mid-period separates latching at the period boundary from live use of the field. A slave hold placed across the start of the high phase shows whether the count and the sample strobe wait for the line. Dropping the enable in mid-phase and then restarting shows that the counters are cleared rather than resumed.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_div_cfg.sv
// Holds the divider fields captured at a period boundary and derives the
// terminal and midpoint counts for each phase.
module scl_div_cfg #(
  parameter int FIELD_W    = 16,
  parameter int SCALE_LOG2 = 3,
  localparam int CNT_W     = FIELD_W + SCALE_LOG2 + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [2*FIELD_W-1:0] div_cfg,
  output logic [CNT_W-1:0]     low_end,
  output logic [CNT_W-1:0]     low_mid,
  output logic [CNT_W-1:0]     high_end,
  output logic [CNT_W-1:0]     high_mid
);
  logic [FIELD_W-1:0] lo_q, hi_q;
  logic [CNT_W-1:0]   lo_len, hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load) begin
      lo_q <= div_cfg[FIELD_W-1:0];
      hi_q <= div_cfg[2*FIELD_W-1:FIELD_W];
    end
  end

  always_comb begin
    lo_len   = (CNT_W'(lo_q) + CNT_W'(1)) << SCALE_LOG2;
    hi_len   = (CNT_W'(hi_q) + CNT_W'(1)) << SCALE_LOG2;
    low_end  = lo_len - CNT_W'(1);
    high_end = hi_len - CNT_W'(1);
    low_mid  = lo_len >> 1;
    high_mid = hi_len >> 1;
  end
endmodule

// File: rtl/scl_div_phase.sv
// Phase sequencer: one counter shared by both phases, held in the high
// phase while the line is still low.
module scl_div_phase
  import scl_div_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] low_end,
  input  logic [CNT_W-1:0] high_end,
  output scl_phase_e       phase,
  output logic [CNT_W-1:0] cnt,
  output logic             fresh,
  output logic             adv,
  output logic             load
);
  logic low_done, high_done;

  assign adv       = (phase != PH_HIGH) || scl_in;
  assign low_done  = (phase == PH_LOW)  && (cnt == low_end);
  assign high_done = (phase == PH_HIGH) && scl_in && (cnt == high_end);
  assign load      = run_en && ((phase == PH_IDLE) || high_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      fresh <= 1'b0;
    end else if (!run_en) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      fresh <= 1'b0;
    end else begin
      fresh <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          phase <= PH_LOW;
          cnt   <= '0;
          fresh <= 1'b1;
        end
        PH_LOW: begin
          if (low_done) begin
            phase <= PH_HIGH;
            cnt   <= '0;
            fresh <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_HIGH: begin
          if (high_done) begin
            phase <= PH_LOW;
            cnt   <= '0;
            fresh <= 1'b1;
          end else if (adv) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/scl_div_strobe.sv
// Edge and midpoint strobes decoded from the phase state.
module scl_div_strobe
  import scl_div_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  scl_phase_e       phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic             fresh,
  input  logic             adv,
  input  logic [CNT_W-1:0] low_mid,
  input  logic [CNT_W-1:0] high_mid,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic             chg_stb,
  output logic             smp_stb
);
  logic in_low, in_high;

  assign in_low   = (phase == PH_LOW);
  assign in_high  = (phase == PH_HIGH);
  assign fall_stb = in_low  && fresh;
  assign rise_stb = in_high && fresh;
  assign chg_stb  = in_low  && (cnt == low_mid);
  assign smp_stb  = in_high && adv && (cnt == high_mid);
endmodule

// File: rtl/scl_split_divider.sv
module scl_split_divider
  import scl_div_pkg::*;
#(
  parameter int FIELD_W    = 16,
  parameter int SCALE_LOG2 = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic [2*FIELD_W-1:0] div_cfg,
  input  logic                 scl_in,
  output logic                 scl_o,
  output logic                 phase_low,
  output logic                 phase_high,
  output logic                 fall_stb,
  output logic                 rise_stb,
  output logic                 chg_stb,
  output logic                 smp_stb
);
  localparam int CNT_W = FIELD_W + SCALE_LOG2 + 1;

  scl_phase_e       phase;
  logic [CNT_W-1:0] cnt, low_end, low_mid, high_end, high_mid;
  logic             fresh, adv, load;

  scl_div_cfg #(.FIELD_W(FIELD_W), .SCALE_LOG2(SCALE_LOG2)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .div_cfg  (div_cfg),
    .low_end  (low_end),
    .low_mid  (low_mid),
    .high_end (high_end),
    .high_mid (high_mid)
  );

  scl_div_phase #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .scl_in   (scl_in),
    .low_end  (low_end),
    .high_end (high_end),
    .phase    (phase),
    .cnt      (cnt),
    .fresh    (fresh),
    .adv      (adv),
    .load     (load)
  );

  scl_div_strobe #(.CNT_W(CNT_W)) u_strobe (
    .phase    (phase),
    .cnt      (cnt),
    .fresh    (fresh),
    .adv      (adv),
    .low_mid  (low_mid),
    .high_mid (high_mid),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb),
    .chg_stb  (chg_stb),
    .smp_stb  (smp_stb)
  );

  assign phase_low  = (phase == PH_LOW);
  assign phase_high = (phase == PH_HIGH);
  assign scl_o      = (phase != PH_LOW);
endmodule

// File: rtl/scl_split_divider_chk.sv
module scl_split_divider_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic scl_in,
  input logic scl_o,
  input logic phase_low,
  input logic phase_high,
  input logic fall_stb,
  input logic rise_stb,
  input logic chg_stb,
  input logic smp_stb
);
  // R2
  no_dual_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase_low && phase_high));

  // R2
  high_follows_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_high && !$past(phase_high)) |-> $past(phase_low));

  // R10
  parked_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (scl_o && !phase_low && !phase_high && !fall_stb &&
                 !rise_stb && !chg_stb && !smp_stb));

  // R9
  fall_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (phase_low && !scl_o));

  // R9
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> !rise_stb);

  // R6
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_high && !scl_in && run_en) |=> phase_high);

  // R8
  sample_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> (phase_high && scl_in));

  // R7
  change_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_stb |-> (phase_low && !fall_stb));
endmodule

bind scl_split_divider scl_split_divider_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .scl_in     (scl_in),
  .scl_o      (scl_o),
  .phase_low  (phase_low),
  .phase_high (phase_high),
  .fall_stb   (fall_stb),
  .rise_stb   (rise_stb),
  .chg_stb    (chg_stb),
  .smp_stb    (smp_stb)
);

// File: tb/tb_scl_split_divider.sv
`timescale 1ns/1ps
module tb_scl_split_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic [31:0] div_cfg = '0;
  logic        scl_in = 1'b1;
  logic        scl_o, phase_low, phase_high, fall_stb, rise_stb, chg_stb, smp_stb;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  scl_split_divider dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .div_cfg(div_cfg),
    .scl_in(scl_in), .scl_o(scl_o), .phase_low(phase_low),
    .phase_high(phase_high), .fall_stb(fall_stb), .rise_stb(rise_stb),
    .chg_stb(chg_stb), .smp_stb(smp_stb)
  );

  // {H, L} per entry, and the expected period 8*((L+1)+(H+1))
  localparam int NV = 6;
  localparam logic [31:0] VEC_CFG [NV] = '{
    {16'd0, 16'd0}, {16'd0, 16'd1}, {16'd1, 16'd0},
    {16'd5, 16'd3}, {16'd2, 16'd2}, {16'd1, 16'd7}
  };
  localparam int VEC_PER [NV] = '{16, 24, 24, 80, 48, 80};

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Starts from idle, runs one full period and one cycle, measures strobes.
  task automatic run_case(input logic [15:0] lo, input logic [15:0] hi,
                          input int exp_p, input string preq);
    int lo_len, hi_len, t_rise, t_chg, t_smp, t_fall, n_rise, n_chg, low_bad;
    lo_len = 8 * (int'(lo) + 1);
    hi_len = 8 * (int'(hi) + 1);
    t_rise = -1; t_chg = -1; t_smp = -1; t_fall = -1;
    n_rise = 0; n_chg = 0; low_bad = 0;
    run_en = 1'b0;
    div_cfg = {hi, lo};
    @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
    chk(fall_stb == 1'b1, "R9", "falling strobe at period start", fall_stb, 1);
    for (int t = 0; t <= exp_p; t++) begin
      if (t > 0) @(negedge clk);
      if (t > 0 && fall_stb && t_fall < 0) t_fall = t;
      if (rise_stb) begin n_rise++; if (t_rise < 0) t_rise = t; end
      if (chg_stb && t < exp_p) begin n_chg++; if (t_chg < 0) t_chg = t; end
      if (smp_stb && t_smp < 0) t_smp = t;
      if (t < lo_len && (!phase_low || scl_o || phase_high)) low_bad++;
    end
    chk(t_rise == lo_len, "R2", "high phase start", t_rise, lo_len);
    chk(low_bad == 0, "R2", "low phase cycles with wrong level", low_bad, 0);
    chk(n_rise == 1, "R9", "rising strobes per period", n_rise, 1);
    chk(t_chg == lo_len / 2 && n_chg == 1, "R7", "change strobe time", t_chg, lo_len / 2);
    chk(t_smp == lo_len + hi_len / 2, "R8", "sample strobe time", t_smp, lo_len + hi_len / 2);
    chk(t_fall == exp_p, preq, "period length", t_fall, exp_p);
    run_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t_rise, t_fall, t_smp, n_rise, off_bad;
    // R10: reset state
    @(negedge clk);
    chk(scl_o && !phase_low && !phase_high, "R10", "levels in reset",
        {scl_o, phase_low, phase_high}, 3'b100);
    chk(!(fall_stb | rise_stb | chg_stb | smp_stb), "R10", "strobes in reset",
        {fall_stb, rise_stb, chg_stb, smp_stb}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Table of divider words: R1 period, R2/R7/R8/R9 timing
    for (int i = 0; i < NV; i++)
      run_case(VEC_CFG[i][15:0], VEC_CFG[i][31:16], VEC_PER[i], (i == 0) ? "R3" : "R1");

    // R4: total divisor D=5 split as H=ceil(D/2), L=D-H
    begin
      int d, h, l;
      d = 5; h = (d + 1) / 2; l = d - h;
      run_case(16'(l), 16'(h), 8 * (d + 2), "R4");
    end

    // R5: change word mid-period, L=1,H=1 then L=3,H=0
    div_cfg = {16'd1, 16'd1};
    @(negedge clk); run_en = 1'b1;
    @(negedge clk);
    t_rise = -1; t_fall = -1; n_rise = 0;
    begin
      int t_rise2, t_fall2;
      t_rise2 = -1; t_fall2 = -1;
      for (int t = 0; t <= 72; t++) begin
        if (t > 0) @(negedge clk);
        if (rise_stb) begin
          if (t_rise < 0) t_rise = t; else if (t_rise2 < 0) t_rise2 = t;
        end
        if (t > 0 && fall_stb) begin
          if (t_fall < 0) t_fall = t; else if (t_fall2 < 0) t_fall2 = t;
        end
        if (t == 5) div_cfg = {16'd0, 16'd3};
      end
      chk(t_rise == 16, "R5", "old low length kept", t_rise, 16);
      chk(t_fall == 32, "R5", "old period kept", t_fall, 32);
      chk(t_rise2 == 64, "R5", "new low length", t_rise2, 64);
      chk(t_fall2 == 72, "R5", "new period", t_fall2, 72);
    end
    run_en = 1'b0;
    @(negedge clk);

    // R6: slave holds SCL low for 5 cycles at start of the high phase, L=H=0
    div_cfg = 32'd0;
    @(negedge clk); run_en = 1'b1;
    @(negedge clk);
    t_fall = -1; t_smp = -1; n_rise = 0;
    for (int t = 0; t <= 21; t++) begin
      if (t > 0) @(negedge clk);
      if (rise_stb) n_rise++;
      if (smp_stb && t_smp < 0) t_smp = t;
      if (t > 0 && fall_stb && t_fall < 0) t_fall = t;
      if (t == 8) scl_in = 1'b0;
      if (t == 13) scl_in = 1'b1;
    end
    chk(t_fall == 21, "R6", "stretched period", t_fall, 21);
    chk(t_smp == 17, "R8", "sample strobe after stretch", t_smp, 17);
    chk(n_rise == 1, "R9", "single rising strobe while stretched", n_rise, 1);
    run_en = 1'b0;
    @(negedge clk);

    // R10: drop enable in mid low phase, then restart with full low phase
    div_cfg = {16'd0, 16'd1};
    @(negedge clk); run_en = 1'b1;
    repeat (6) @(negedge clk);
    run_en = 1'b0;
    off_bad = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (!scl_o || phase_low || phase_high || fall_stb || rise_stb || chg_stb || smp_stb)
        off_bad++;
    end
    chk(off_bad == 0, "R10", "cycles not parked while disabled", off_bad, 0);
    run_case(16'd1, 16'd0, 24, "R10");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule